// File: doc/BRIEF.md
# Transmit Offload Header Stripper

This block sits in a byte-wide transmit path, after the logic that fetches buffer descriptors and before the MAC framing logic. Each frame arrives as one or more data buffers. Per-byte side-band bits mark the first byte of the frame, the last byte of each buffer and the last byte of the frame, and carry the descriptor's offload-enable flag. The offload decision for a frame is taken only from the flag that comes with the frame's first byte. When it is set, the first eight bytes of the first buffer form a control header. The block consumes that header, decodes it into a parameter register for the downstream checksum and tagging logic, and forwards only the bytes that follow it.

The parameter register is cleared at every frame start. It is loaded, together with a one-cycle strobe, when the last header byte is consumed. This strobe always comes before the frame's first forwarded byte. Two kinds of malformed input are reported on the output frame-end side-band: a first buffer that ends before the header is complete, and a frame that ends inside the header. Both input and output are valid/ready byte streams. A single output register means that back-pressure stalls header consumption and payload forwarding in the same way.

Top module: `txo_strip`

## Requirements
- R1: After reset, out_valid and prm_valid are 0, every parameter output is 0 and in_ready is 1.
- R2: A frame whose first byte has in_ofl = 0 is forwarded unchanged, byte for byte and in order. out_sof is set on its first byte only, out_eof on its last byte only, and out_err is 0. No strobe occurs.
- R3: A frame whose first byte has in_ofl = 1 loses its first 8 bytes. The bytes after them are forwarded in order, with out_sof on the first forwarded byte and out_eof on the last.
- R4: Header decode, with header byte k being the k-th byte accepted. prm_flags bit 0 = byte1 bit0 (VLAN insert), bit 1 = byte1 bit1 (IP), bit 2 = byte1 bit2 (IPv6), bit 3 = byte1 bit3 (TCP/UDP), bit 4 = byte1 bit4 (UDP), bit 5 = byte1 bit5 (IP header checksum), bit 6 = byte1 bit6 (L4 checksum), bit 7 = byte1 bit7 (no pseudo-header), bit 8 = byte0 bit7 (PTP). prm_l4_off = byte2, prm_l3_off = byte3, prm_ph_csum = {byte4, byte5} and prm_vlan_ctl = {byte6, byte7}.
- R5: prm_valid is high for exactly one cycle: the cycle after the edge that accepts header byte 7. It comes before the frame's first forwarded byte is visible on the output.
- R6: The parameter outputs become 0 when a frame's first byte is accepted, and then hold their value until the next strobe or frame start.
- R7: in_ofl is ignored on every byte except a frame's first byte.
- R8: If the first buffer of an offloaded frame ends (in_bend) before header byte 7 and the frame continues, the header bytes received are dropped. Forwarding resumes with out_sof on the next byte, out_err = 1 is set on the out_eof byte only, there is no strobe, and the parameters stay 0.
- R9: If an offloaded frame ends (in_eof) on any of its first 8 bytes, exactly one byte is output for that frame: the last byte received, with out_sof, out_eof and out_err all set. There is no strobe.
- R10: An offloaded frame whose first buffer holds exactly the 8 header bytes is handled without error, and its payload comes from the later buffers.
- R11: in_ready = !out_valid || out_ready. While out_valid is high and out_ready is low, the output bytes and flags hold. No byte is lost or duplicated under any stall pattern.
- R12: A forwarded byte appears on the output in the cycle right after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_bend | input | 1 | Last byte of the current buffer |
| in_eof | input | 1 | Last byte of the frame |
| in_ofl | input | 1 | Offload-enable flag of the descriptor (used on the first byte only) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eof | output | 1 | Last forwarded byte of a frame |
| out_err | output | 1 | Malformed header, valid together with out_eof |
| prm_valid | output | 1 | One-cycle strobe: parameters loaded |
| prm_flags | output | 9 | Decoded offload flags |
| prm_l4_off | output | 8 | Layer-4 offset byte |
| prm_l3_off | output | 8 | Layer-3 offset byte |
| prm_ph_csum | output | 16 | Pseudo-header checksum |
| prm_vlan_ctl | output | 16 | VLAN control word |

## Verification
The output register appears in the cycle after the accepting edge, and so does the parameter strobe after header byte 7. The bench therefore drives inputs 4 ns after a rising edge, samples handshakes and strobes at the falling edge, and checks the first-byte latency right after the accepting edge. Each output byte is recorded in the cycle in which out_valid and out_ready are both high. The strobe is stamped with the number of bytes already forwarded, which proves that it comes first. Stalled bytes are compared across consecutive falling edges to show that they hold.

// File: rtl/txo_pkg.sv
`timescale 1ns/1ps
package txo_pkg;
  localparam int BYTE_W  = 8;
  localparam int HDR_LEN = 8;
  localparam int IDX_W   = $clog2(HDR_LEN);
  localparam int NFLAG   = 9;
  localparam int HDR_W   = HDR_LEN * BYTE_W;

  typedef struct packed {
    logic [NFLAG-1:0]    flags;
    logic [BYTE_W-1:0]   l4_off;
    logic [BYTE_W-1:0]   l3_off;
    logic [2*BYTE_W-1:0] ph_csum;
    logic [2*BYTE_W-1:0] vlan_ctl;
  } ofl_prm_t;

  // raw holds header byte 0 in its top byte, byte 7 in its bottom byte
  function automatic ofl_prm_t decode_hdr(input logic [HDR_W-1:0] raw);
    ofl_prm_t p;
    p.flags    = {raw[HDR_W-1], raw[HDR_W-BYTE_W-1 -: BYTE_W]};
    p.l4_off   = raw[HDR_W-2*BYTE_W-1 -: BYTE_W];
    p.l3_off   = raw[HDR_W-3*BYTE_W-1 -: BYTE_W];
    p.ph_csum  = raw[HDR_W-4*BYTE_W-1 -: 2*BYTE_W];
    p.vlan_ctl = raw[2*BYTE_W-1:0];
    return p;
  endfunction

  function automatic logic hdr_last(input logic [IDX_W-1:0] idx);
    return idx == IDX_W'(HDR_LEN-1);
  endfunction
endpackage

// File: rtl/txo_frame_ctl.sv
`timescale 1ns/1ps
module txo_frame_ctl
  import txo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             in_sof,
  input  logic             in_bend,
  input  logic             in_eof,
  input  logic             in_ofl,
  output logic             cur_hdr,
  output logic [IDX_W-1:0] cur_idx,
  output logic             ev_start,
  output logic             ev_done,
  output logic             ev_short,
  output logic             ev_stub,
  output logic             emit,
  output logic             emit_sof,
  output logic             emit_err
);
  logic             hdr_q;
  logic [IDX_W-1:0] idx_q;
  logic             sofp_q;
  logic             errp_q;
  logic             at_end;

  // the offload flag only matters on the frame's first byte
  always_comb begin
    cur_hdr = in_sof ? in_ofl : hdr_q;
    cur_idx = in_sof ? '0 : idx_q;
    at_end  = hdr_last(cur_idx);
  end

  assign ev_start = acc && in_sof;
  assign ev_stub  = acc && cur_hdr && in_eof;
  assign ev_done  = acc && cur_hdr && at_end && !in_eof;
  assign ev_short = acc && cur_hdr && in_bend && !at_end && !in_eof;

  // header bytes are swallowed unless the frame dies inside them
  assign emit     = !cur_hdr || in_eof;
  assign emit_sof = cur_hdr || in_sof || sofp_q;
  assign emit_err = cur_hdr || (in_eof && !in_sof && errp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= 1'b0;
      idx_q  <= '0;
      sofp_q <= 1'b0;
      errp_q <= 1'b0;
    end else if (acc) begin
      if (cur_hdr) begin
        if (in_eof) begin
          hdr_q  <= 1'b0;
          idx_q  <= '0;
          sofp_q <= 1'b0;
          errp_q <= 1'b0;
        end else if (at_end || in_bend) begin
          hdr_q  <= 1'b0;
          idx_q  <= '0;
          sofp_q <= 1'b1;
          errp_q <= !at_end;
        end else begin
          hdr_q  <= 1'b1;
          idx_q  <= cur_idx + IDX_W'(1);
          sofp_q <= 1'b0;
          errp_q <= 1'b0;
        end
      end else begin
        hdr_q  <= 1'b0;
        sofp_q <= 1'b0;
        if (in_eof || in_sof) errp_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txo_hdr_capture.sv
`timescale 1ns/1ps
module txo_hdr_capture
  import txo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_hdr,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              ev_start,
  input  logic              ev_done,
  output ofl_prm_t          prm,
  output logic              prm_stb
);
  localparam int SH_W = (HDR_LEN-1) * BYTE_W;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      prm     <= '0;
      prm_stb <= 1'b0;
    end else begin
      prm_stb <= ev_done;
      if (acc_hdr) sh_q <= {sh_q[SH_W-BYTE_W-1:0], in_data};
      if (ev_done)       prm <= decode_hdr({sh_q, in_data});
      else if (ev_start) prm <= '0;
    end
  end
endmodule

// File: rtl/txo_out_reg.sv
`timescale 1ns/1ps
module txo_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         sof,
  input  logic         eof,
  input  logic         err,
  input  logic         out_ready,
  output logic         space,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_sof,
  output logic         out_eof,
  output logic         out_err
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_err   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d;
      out_sof   <= sof;
      out_eof   <= eof;
      out_err   <= err && eof;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/txo_strip.sv
`timescale 1ns/1ps
module txo_strip
  import txo_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BYTE_W-1:0]   in_data,
  input  logic                in_sof,
  input  logic                in_bend,
  input  logic                in_eof,
  input  logic                in_ofl,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [BYTE_W-1:0]   out_data,
  output logic                out_sof,
  output logic                out_eof,
  output logic                out_err,
  output logic                prm_valid,
  output logic [NFLAG-1:0]    prm_flags,
  output logic [BYTE_W-1:0]   prm_l4_off,
  output logic [BYTE_W-1:0]   prm_l3_off,
  output logic [2*BYTE_W-1:0] prm_ph_csum,
  output logic [2*BYTE_W-1:0] prm_vlan_ctl
);
  logic             space;
  logic             acc;
  logic             cur_hdr;
  logic [IDX_W-1:0] cur_idx;
  logic             ev_start;
  logic             ev_done;
  logic             ev_short;
  logic             ev_stub;
  logic             emit;
  logic             emit_sof;
  logic             emit_err;
  logic             load;
  ofl_prm_t         prm;

  assign in_ready = space;
  assign acc      = in_valid && space;
  assign load     = acc && emit;

  txo_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .in_sof(in_sof), .in_bend(in_bend), .in_eof(in_eof), .in_ofl(in_ofl),
    .cur_hdr(cur_hdr), .cur_idx(cur_idx),
    .ev_start(ev_start), .ev_done(ev_done), .ev_short(ev_short), .ev_stub(ev_stub),
    .emit(emit), .emit_sof(emit_sof), .emit_err(emit_err)
  );

  txo_hdr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .acc_hdr(acc && cur_hdr), .in_data(in_data),
    .ev_start(ev_start), .ev_done(ev_done), .prm(prm), .prm_stb(prm_valid)
  );

  txo_out_reg #(.W(BYTE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .d(in_data),
    .sof(emit_sof), .eof(in_eof), .err(emit_err), .out_ready(out_ready),
    .space(space), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err)
  );

  assign prm_flags    = prm.flags;
  assign prm_l4_off   = prm.l4_off;
  assign prm_l3_off   = prm.l3_off;
  assign prm_ph_csum  = prm.ph_csum;
  assign prm_vlan_ctl = prm.vlan_ctl;
endmodule

// File: rtl/txo_strip_chk.sv
`timescale 1ns/1ps
module txo_strip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_err,
  input logic       prm_valid,
  input logic       ev_done,
  input logic       ev_short,
  input logic       ev_stub
);
  assert_stall_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
                                && $stable(out_eof) && $stable(out_err));

  assert_err_with_eof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_eof);

  assert_strobe_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> prm_valid);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prm_valid |=> !prm_valid);

  assert_strobe_before_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prm_valid |-> !out_valid);

  assert_short_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_short |=> !prm_valid);

  assert_stub_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stub |=> out_valid && out_sof && out_eof && out_err && !prm_valid);
endmodule

bind txo_strip txo_strip_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
  .out_eof(out_eof), .out_err(out_err), .prm_valid(prm_valid),
  .ev_done(ev_done), .ev_short(ev_short), .ev_stub(ev_stub)
);

// File: tb/sim_txo_strip.sv
`timescale 1ns/1ps
module sim_txo_strip;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_sof = 1'b0, in_bend = 1'b0, in_eof = 1'b0, in_ofl = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_sof, out_eof, out_err;
  logic        prm_valid;
  logic [8:0]  prm_flags;
  logic [7:0]  prm_l4_off, prm_l3_off;
  logic [15:0] prm_ph_csum, prm_vlan_ctl;

  always #10 clk = ~clk;

  txo_strip u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_bend(in_bend), .in_eof(in_eof),
    .in_ofl(in_ofl), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err),
    .prm_valid(prm_valid), .prm_flags(prm_flags), .prm_l4_off(prm_l4_off),
    .prm_l3_off(prm_l3_off), .prm_ph_csum(prm_ph_csum), .prm_vlan_ctl(prm_vlan_ctl)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------- output monitor ----------
  logic [7:0] oq_d[$];
  bit         oq_sof[$], oq_eof[$], oq_err[$];
  int         strobe_cnt = 0;
  int         strobe_pos = -1;
  bit         hold_armed = 1'b0;
  logic [7:0] hold_d;

  always @(negedge clk) begin
    if (rst_n && hold_armed)
      check(out_valid && out_data == hold_d, "R11", "stalled byte held", out_data, hold_d);
    hold_armed = rst_n && out_valid && !out_ready;
    hold_d     = out_data;
    if (rst_n && out_valid && out_ready) begin
      oq_d.push_back(out_data);
      oq_sof.push_back(out_sof);
      oq_eof.push_back(out_eof);
      oq_err.push_back(out_err);
    end
    if (rst_n && prm_valid) begin
      strobe_cnt++;
      strobe_pos = oq_d.size();
    end
  end

  // ---------- back-pressure source ----------
  bit       stall_mode = 1'b0;
  logic [7:0] lf = 8'hA5;
  always @(posedge clk) begin
    #4;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    out_ready = stall_mode ? (lf[0] ^ lf[3]) : 1'b1;
  end

  // ---------- stimulus helpers ----------
  logic [7:0] sd[$];
  bit         sb[$];
  logic [7:0] eq[$];
  logic [7:0] hb[8];

  task automatic send_byte(input logic [7:0] d, input bit s, input bit b,
                           input bit e, input bit o);
    in_valid = 1'b1; in_data = d; in_sof = s; in_bend = b; in_eof = e; in_ofl = o;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #4;
    in_valid = 1'b0; in_sof = 1'b0; in_bend = 1'b0; in_eof = 1'b0; in_ofl = 1'b0;
  endtask

  task automatic clear_all();
    sd.delete(); sb.delete(); eq.delete();
    oq_d.delete(); oq_sof.delete(); oq_eof.delete(); oq_err.delete();
    strobe_cnt = 0; strobe_pos = -1;
  endtask

  task automatic push_hdr();
    for (int i = 0; i < 8; i++) begin sd.push_back(hb[i]); sb.push_back(1'b0); end
  endtask

  task automatic add_buf(input int n, input logic [7:0] base, input bit to_exp);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = base + 8'(i * 7);
      sd.push_back(v);
      sb.push_back(i == n - 1);
      if (to_exp) eq.push_back(v);
    end
  endtask

  task automatic send_frame(input bit ofl, input bit later_ofl);
    for (int i = 0; i < sd.size(); i++)
      send_byte(sd[i], i == 0, sb[i], i == sd.size() - 1, (i == 0) ? ofl : later_ofl);
  endtask

  task automatic drain();
    stall_mode = 1'b0;
    repeat (8) @(posedge clk);
    #4;
  endtask

  // header bytes built straight from the field layout
  task automatic mk_hdr(input logic [8:0] f, input logic [7:0] l4, input logic [7:0] l3,
                        input logic [15:0] ph, input logic [15:0] vl);
    hb[0] = {f[8], 7'h00}; hb[1] = f[7:0]; hb[2] = l4; hb[3] = l3;
    hb[4] = ph[15:8];      hb[5] = ph[7:0]; hb[6] = vl[15:8]; hb[7] = vl[7:0];
  endtask

  task automatic cmp_out(input string tag, input bit exp_err);
    check(oq_d.size() == eq.size(), tag, "byte count", oq_d.size(), eq.size());
    for (int i = 0; i < oq_d.size() && i < eq.size(); i++) begin
      check(oq_d[i] == eq[i], tag, $sformatf("byte %0d", i), oq_d[i], eq[i]);
      check(oq_sof[i] == (i == 0), tag, $sformatf("sof at %0d", i), oq_sof[i], i == 0);
      check(oq_eof[i] == (i == eq.size() - 1), tag, $sformatf("eof at %0d", i),
            oq_eof[i], i == eq.size() - 1);
      check(oq_err[i] == (exp_err && i == eq.size() - 1), tag, $sformatf("err at %0d", i),
            oq_err[i], exp_err && i == eq.size() - 1);
    end
  endtask

  task automatic check_prm(input string tag, input logic [8:0] f, input logic [7:0] l4,
                           input logic [7:0] l3, input logic [15:0] ph, input logic [15:0] vl);
    check(prm_flags == f,     tag, "flags",    prm_flags, f);
    check(prm_l4_off == l4,   tag, "l4 off",   prm_l4_off, l4);
    check(prm_l3_off == l3,   tag, "l3 off",   prm_l3_off, l3);
    check(prm_ph_csum == ph,  tag, "ph csum",  prm_ph_csum, ph);
    check(prm_vlan_ctl == vl, tag, "vlan ctl", prm_vlan_ctl, vl);
  endtask

  // ---------- scenarios ----------
  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    check(prm_valid == 1'b0, "R1", "prm_valid", prm_valid, 0);
    check(in_ready == 1'b1,  "R1", "in_ready",  in_ready, 1);
    check_prm("R1", 9'h0, 8'h0, 8'h0, 16'h0, 16'h0);
  endtask

  task automatic t_latency();
    clear_all();
    send_byte(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0);
    check(out_valid == 1'b1, "R12", "valid after accept edge", out_valid, 1);
    check(out_data == 8'h5A, "R12", "data after accept edge", out_data, 8'h5A);
    check(out_sof && out_eof, "R12", "sof+eof single byte", {out_sof, out_eof}, 2'b11);
    drain();
  endtask

  task automatic t_offload();
    clear_all();
    mk_hdr(9'h06B, 8'd34, 8'd14, 16'hBEEF, 16'h0123);
    push_hdr();
    add_buf(4, 8'h10, 1'b1);
    add_buf(6, 8'h40, 1'b1);
    send_frame(1'b1, 1'b0);
    drain();
    cmp_out("R3", 1'b0);
    check(strobe_cnt == 1, "R5", "strobe count", strobe_cnt, 1);
    check(strobe_pos == 0, "R5", "strobe before payload", strobe_pos, 0);
    check_prm("R4", 9'h06B, 8'd34, 8'd14, 16'hBEEF, 16'h0123);
  endtask

  task automatic t_plain();
    clear_all();
    add_buf(3, 8'h71, 1'b1);
    add_buf(4, 8'h90, 1'b1);
    send_frame(1'b0, 1'b0);
    drain();
    cmp_out("R2", 1'b0);
    check(strobe_cnt == 0, "R2", "no strobe", strobe_cnt, 0);
    check_prm("R6", 9'h0, 8'h0, 8'h0, 16'h0, 16'h0);
  endtask

  task automatic t_later_flag();
    clear_all();
    add_buf(2, 8'h21, 1'b1);
    add_buf(5, 8'hC0, 1'b1);
    send_frame(1'b0, 1'b1);
    drain();
    cmp_out("R7", 1'b0);
    check(strobe_cnt == 0, "R7", "no strobe from later flag", strobe_cnt, 0);
  endtask

  task automatic t_exact();
    clear_all();
    mk_hdr(9'h1FF, 8'd42, 8'd18, 16'h55AA, 16'hE00A);
    push_hdr();
    sb[7] = 1'b1;
    add_buf(5, 8'h03, 1'b1);
    send_frame(1'b1, 1'b1);
    drain();
    cmp_out("R10", 1'b0);
    check(strobe_cnt == 1, "R10", "strobe count", strobe_cnt, 1);
    check_prm("R10", 9'h1FF, 8'd42, 8'd18, 16'h55AA, 16'hE00A);
  endtask

  task automatic t_short();
    clear_all();
    add_buf(5, 8'hD1, 1'b0);
    add_buf(4, 8'h61, 1'b1);
    send_frame(1'b1, 1'b0);
    drain();
    cmp_out("R8", 1'b1);
    check(strobe_cnt == 0, "R8", "no strobe", strobe_cnt, 0);
    check_prm("R8", 9'h0, 8'h0, 8'h0, 16'h0, 16'h0);
  endtask

  task automatic t_stub();
    clear_all();
    add_buf(3, 8'hA1, 1'b0);
    eq.push_back(8'hA1 + 8'd14);
    send_frame(1'b1, 1'b0);
    drain();
    cmp_out("R9", 1'b1);
    check(strobe_cnt == 0, "R9", "no strobe", strobe_cnt, 0);
  endtask

  task automatic t_backpressure();
    clear_all();
    mk_hdr(9'h10C, 8'd54, 8'd14, 16'h1234, 16'h8100);
    push_hdr();
    add_buf(3, 8'h30, 1'b1);
    add_buf(9, 8'h50, 1'b1);
    add_buf(8, 8'h80, 1'b1);
    stall_mode = 1'b1;
    send_frame(1'b1, 1'b0);
    drain();
    cmp_out("R11", 1'b0);
    check(strobe_pos == 0, "R11", "strobe before payload under stall", strobe_pos, 0);
    check_prm("R11", 9'h10C, 8'd54, 8'd14, 16'h1234, 16'h8100);
    clear_all();
    add_buf(12, 8'h07, 1'b1);
    stall_mode = 1'b1;
    send_frame(1'b0, 1'b1);
    drain();
    cmp_out("R11", 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #4;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #4;
    t_latency();
    t_offload();
    t_plain();
    t_later_flag();
    t_exact();
    t_short();
    t_stub();
    t_backpressure();
    finish_run();
  end
endmodule